// File: doc/BRIEF.md
# Converter Hit Data Block Framer

This block gathers the 32-bit words that a time-to-digital converter delivers for one event and sends them out as a single data block: a header word followed by the kept payload words. The header holds the block type, an overflow indication and the payload size in bytes. Because the size is known only once the event has ended, the payload is held in an internal buffer and the header is built afterwards. The header and the payload then leave on consecutive cycles.

Each incoming word is sorted by its top bits. The sorter recognises hit measurements, optional event header and trailer words, error words and padding. A configuration input removes the optional header and trailer words. Error words leave with their meaningless flag cleared. Two sticky outputs report whether the event contained the size-limit or the trigger-loss error. Words with an unknown type code are discarded and counted.

The controller is a four-state machine:
- IDLE accepts the first word of an event. It goes to COLLECT, or straight to HEADER when that word is also the last.
- COLLECT accepts words and goes to HEADER on the last one.
- HEADER emits the header word. It goes to IDLE when the payload is empty and to DRAIN otherwise.
- DRAIN emits the stored words in order and returns to IDLE after the final one.

Top module: `tdc_block_framer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, both sticky error outputs are 0 and bad_count is 0.
- R2: Hit words (bits 31:29 = 3'b010) and padding words (bits 31:28 = 4'h7) are forwarded unchanged, in arrival order, after the header word.
- R3: The first output word of a block is the header. Its bits 31:28 are 4'h0, bits 27:17 are 0 and bits 15:0 are 4 times the number of payload words. out_last is 1 only on the final word of the block.
- R4: When cfg_strip is 1, words with bits 31:28 = 4'h2 (event header) or 4'h3 (event trailer) are dropped and not counted in the length. When cfg_strip is 0, they are forwarded and counted.
- R5: An error word (bits 31:28 = 4'h6) is forwarded with bit 14 forced to 0 and all other bits unchanged.
- R6: err_size_limit and err_trig_lost are set when an accepted error word of the current event has bit 12 or bit 13 set, respectively. They hold until the first word of the next event is accepted, which reloads them from that word.
- R7: Words whose bits 31:28 are 4'h0, 4'h1 or 4'h8 to 4'hF are dropped. Each one adds 1 to bad_count, which saturates at its maximum and is cleared only by reset.
- R8: Header bit 16 is 1 when in_ovf was high with any accepted word of the event, or when more than DEPTH words were to be kept. Kept words beyond DEPTH are discarded and the length becomes 4*DEPTH.
- R9: in_ready is 0 from the cycle after the last word is accepted until the block has been emitted. The header and payload words leave on consecutive cycles with out_valid high.
- R10: An event whose words are all dropped produces a header alone, with length 0 and out_last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip | input | 1 | Drop optional event header/trailer words |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Converter word |
| in_last | input | 1 | Word closes the event |
| in_ovf | input | 1 | Upstream event FIFO overflowed |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Header or payload word |
| out_last | output | 1 | Final word of the block |
| err_size_limit | output | 1 | Sticky: size-limit error seen this event |
| err_trig_lost | output | 1 | Sticky: trigger-loss error seen this event |
| bad_count | output | CNT_W | Saturating count of unknown-type words |

## Verification
Two cases are hard to reach from the ports. One is buffer exhaustion: it needs an event with more kept words than DEPTH. The other is a saturated bad-word counter: it needs hundreds of unknown-type words before the count stops moving. The bench builds one event of DEPTH+3 hits to check the truncated length and the overflow bit. It builds another of 300 unknown words, which hits saturation and also produces a header-only block. The reloading of the sticky flags is checked across back-to-back events whose error words carry different flag sets.

// File: rtl/tdc_framer_pkg.sv
package tdc_framer_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        WC_HIT,
        WC_EVHDR,
        WC_EVTRL,
        WC_ERR,
        WC_PAD,
        WC_BAD
    } word_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HEADER,
        ST_DRAIN
    } framer_state_e;

    function automatic word_class_e classify(input logic [3:0] code);
        word_class_e c;
        unique case (code)
            4'h2:        c = WC_EVHDR;
            4'h3:        c = WC_EVTRL;
            4'h4, 4'h5:  c = WC_HIT;
            4'h6:        c = WC_ERR;
            4'h7:        c = WC_PAD;
            default:     c = WC_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tdc_word_sorter.sv
module tdc_word_sorter
    import tdc_framer_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              strip_i,
    output logic              keep_o,
    output logic              bad_o,
    output logic              size_flag_o,
    output logic              trig_flag_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int IGN_BIT  = 14;
    localparam int SIZE_BIT = 12;
    localparam int TRIG_BIT = 13;

    word_class_e cls;

    always_comb begin
        cls         = classify(word_i[31:28]);
        word_o      = word_i;
        keep_o      = 1'b0;
        bad_o       = 1'b0;
        size_flag_o = 1'b0;
        trig_flag_o = 1'b0;
        unique case (cls)
            WC_HIT, WC_PAD: keep_o = 1'b1;
            WC_EVHDR, WC_EVTRL: keep_o = !strip_i;
            WC_ERR: begin
                keep_o          = 1'b1;
                word_o[IGN_BIT] = 1'b0;
                size_flag_o     = word_i[SIZE_BIT];
                trig_flag_o     = word_i[TRIG_BIT];
            end
            default: bad_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/tdc_payload_store.sv
module tdc_payload_store #(
    parameter int DEPTH  = 32,
    parameter int WIDTH  = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tdc_err_tracker.sv
module tdc_err_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             start_i,
    input  logic             size_flag_i,
    input  logic             trig_flag_i,
    input  logic             bad_i,
    output logic             size_sticky_o,
    output logic             trig_sticky_o,
    output logic [CNT_W-1:0] bad_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_sticky_o <= 1'b0;
            trig_sticky_o <= 1'b0;
        end else if (accept_i && start_i) begin
            size_sticky_o <= size_flag_i;
            trig_sticky_o <= trig_flag_i;
        end else if (accept_i) begin
            size_sticky_o <= size_sticky_o | size_flag_i;
            trig_sticky_o <= trig_sticky_o | trig_flag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_cnt_o <= '0;
        end else if (accept_i && bad_i && bad_cnt_o != CNT_MAX) begin
            bad_cnt_o <= bad_cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/tdc_block_framer.sv
module tdc_block_framer
    import tdc_framer_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strip,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_word,
    input  logic             in_last,
    input  logic             in_ovf,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             out_last,
    output logic             err_size_limit,
    output logic             err_trig_lost,
    output logic [CNT_W-1:0] bad_count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [3:0] BLK_TYPE = 4'h0;

    framer_state_e state, state_nxt;

    logic              accept, start, full;
    logic              keep, bad, size_flag, trig_flag;
    logic [31:0]       fwd_word, rd_data;
    logic [CW-1:0]     wr_cnt, rd_ptr;
    logic              ev_ovf;
    logic [15:0]       len_bytes;
    logic              drain_last;

    assign accept     = in_valid && in_ready;
    assign start      = (state == ST_IDLE);
    assign full       = (wr_cnt == FULL_CNT);
    assign len_bytes  = 16'({wr_cnt, 2'b00});
    assign drain_last = (rd_ptr == wr_cnt - CW'(1));

    tdc_word_sorter u_sorter (
        .word_i      (in_word),
        .strip_i     (cfg_strip),
        .keep_o      (keep),
        .bad_o       (bad),
        .size_flag_o (size_flag),
        .trig_flag_o (trig_flag),
        .word_o      (fwd_word)
    );

    tdc_payload_store #(
        .DEPTH (DEPTH),
        .WIDTH (32)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept && keep && !full),
        .wr_addr (wr_cnt[AW-1:0]),
        .wr_data (fwd_word),
        .rd_addr (rd_ptr[AW-1:0]),
        .rd_data (rd_data)
    );

    tdc_err_tracker #(
        .CNT_W (CNT_W)
    ) u_err (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .start_i       (start),
        .size_flag_i   (size_flag),
        .trig_flag_i   (trig_flag),
        .bad_i         (bad),
        .size_sticky_o (err_size_limit),
        .trig_sticky_o (err_trig_lost),
        .bad_cnt_o     (bad_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = in_last ? ST_HEADER : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (accept && in_last) begin
                    state_nxt = ST_HEADER;
                end
            end
            ST_HEADER: begin
                state_nxt = (wr_cnt == '0) ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (drain_last) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state)
            ST_IDLE, ST_COLLECT: in_ready = 1'b1;
            ST_HEADER: begin
                out_valid = 1'b1;
                out_data  = {BLK_TYPE, 11'd0, ev_ovf, len_bytes};
                out_last  = (wr_cnt == '0);
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_data  = rd_data;
                out_last  = drain_last;
            end
            default: ;
        endcase
    end

    // Payload bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_ptr <= '0;
            ev_ovf <= 1'b0;
        end else begin
            if (accept) begin
                if (start) begin
                    ev_ovf <= in_ovf;
                end else begin
                    ev_ovf <= ev_ovf | in_ovf | (keep && full);
                end
                if (keep && !full) begin
                    wr_cnt <= wr_cnt + CW'(1);
                end
            end
            if (state == ST_HEADER) begin
                rd_ptr <= '0;
            end else if (state == ST_DRAIN) begin
                if (drain_last) begin
                    rd_ptr <= '0;
                    wr_cnt <= '0;
                end else begin
                    rd_ptr <= rd_ptr + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tdc_framer_chk.sv
module tdc_framer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [31:0]      out_data,
    input logic             out_last,
    input logic             err_size_limit,
    input logic             err_trig_lost,
    input logic [CNT_W-1:0] bad_count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    assert_hdr_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data[31:17] == 15'd0 && out_data[1:0] == 2'b00));

    assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !out_valid);

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_err_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[31:28] == 4'h6) |-> !out_data[14]);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(err_size_limit) && $stable(err_trig_lost)));

    assert_bad_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bad_count >= $past(bad_count)));

    assert_bad_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_count == CMAX) |=> (bad_count == CMAX));

endmodule

bind tdc_block_framer tdc_framer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_last       (out_last),
    .err_size_limit (err_size_limit),
    .err_trig_lost  (err_trig_lost),
    .bad_count      (bad_count)
);

// File: tb/tdc_block_framer_tb.sv
module tdc_block_framer_tb;
    localparam int DEPTH = 32;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_strip = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_word = '0;
    logic             in_last = 1'b0;
    logic             in_ovf = 1'b0;
    logic             out_valid;
    logic [31:0]      out_data;
    logic             out_last;
    logic             err_size_limit;
    logic             err_trig_lost;
    logic [CNT_W-1:0] bad_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int exp_bad = 0;

    logic [31:0] tx_q[$];
    logic        ovf_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];
    logic        got_last[$];

    always #2.5 clk = ~clk;

    tdc_block_framer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_strip      (cfg_strip),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_word        (in_word),
        .in_last        (in_last),
        .in_ovf         (in_ovf),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_last       (out_last),
        .err_size_limit (err_size_limit),
        .err_trig_lost  (err_trig_lost),
        .bad_count      (bad_count)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_q.push_back(out_data);
            got_last.push_back(out_last);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_q();
        tx_q.delete(); ovf_q.delete(); exp_q.delete();
        got_q.delete(); got_last.delete();
    endtask

    task automatic add(input logic [31:0] w, input logic ovf = 1'b0);
        tx_q.push_back(w);
        ovf_q.push_back(ovf);
    endtask

    // Send the queued event, wait for the block, compare it with exp_q.
    task automatic run_event(input string req);
        int n;
        int last_seen;
        int wait_cnt;
        n = tx_q.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = tx_q[i];
            in_ovf   = ovf_q[i];
            in_last  = (i == n - 1);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_ovf = 1'b0;
        last_seen = 0;
        wait_cnt = 0;
        while (!last_seen && wait_cnt < 4 * DEPTH + 20) begin
            @(negedge clk);
            wait_cnt++;
            foreach (got_last[k]) if (got_last[k]) last_seen = 1;
        end
        @(negedge clk);
        check({req, " block size"}, 32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check({req, " word"}, got_q[i], exp_q[i]);
            check({req, " out_last"}, 32'(got_last[i]), 32'(i == exp_q.size() - 1));
        end
        check("R9 ready after block", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reset();
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd1);
        check("R1 stickies", {30'd0, err_size_limit, err_trig_lost}, 32'd0);
        check("R1 bad_count", 32'(bad_count), 32'd0);
    endtask

    task automatic t_hits_pad();
        clear_q(); cfg_strip = 1'b0;
        add(32'h42A0_0001); add(32'h5013_FFFF); add(32'h7000_0000);
        exp_q = '{32'h0000_000C, 32'h42A0_0001, 32'h5013_FFFF, 32'h7000_0000};
        run_event("R2 R3 hits+pad");
    endtask

    task automatic t_hdr_keep();
        clear_q(); cfg_strip = 1'b0;
        add(32'h2123_4567); add(32'h4000_0100); add(32'h3123_4003);
        exp_q = '{32'h0000_000C, 32'h2123_4567, 32'h4000_0100, 32'h3123_4003};
        run_event("R4 strip off");
    endtask

    task automatic t_hdr_strip();
        clear_q(); cfg_strip = 1'b1;
        add(32'h2123_4567); add(32'h4000_0100); add(32'h3123_4003);
        exp_q = '{32'h0000_0004, 32'h4000_0100};
        run_event("R4 strip on");
        clear_q();
        add(32'h2ABC_D000);
        exp_q = '{32'h0000_0000};
        run_event("R10 stripped-only event");
        cfg_strip = 1'b0;
    endtask

    task automatic t_errors();
        clear_q();
        add(32'h6500_7FFF); add(32'h4800_0002);
        exp_q = '{32'h0000_0008, 32'h6500_3FFF, 32'h4800_0002};
        run_event("R5 mask bit14");
        check("R6 size sticky set", 32'(err_size_limit), 32'd1);
        check("R6 trig sticky set", 32'(err_trig_lost), 32'd1);
        clear_q();
        add(32'h4000_0003); add(32'h6000_1000);
        exp_q = '{32'h0000_0008, 32'h4000_0003, 32'h6000_1000};
        run_event("R6 size only");
        check("R6 size sticky", 32'(err_size_limit), 32'd1);
        check("R6 trig sticky reloaded", 32'(err_trig_lost), 32'd0);
        clear_q();
        add(32'h6300_4000);
        exp_q = '{32'h0000_0004, 32'h6300_0000};
        run_event("R5 bit14 only");
        check("R6 stickies cleared", {30'd0, err_size_limit, err_trig_lost}, 32'd0);
    endtask

    task automatic t_unknown();
        clear_q();
        add(32'h1000_0000); add(32'h4100_0004); add(32'h8FFF_FFFF); add(32'h0000_0001);
        exp_q = '{32'h0000_0004, 32'h4100_0004};
        run_event("R7 unknown dropped");
        exp_bad += 3;
        check("R7 bad_count", 32'(bad_count), 32'(exp_bad));
        clear_q();
        add(32'hF000_0000);
        exp_q = '{32'h0000_0000};
        run_event("R10 empty event");
        exp_bad += 1;
        check("R7 bad_count empty", 32'(bad_count), 32'(exp_bad));
    endtask

    task automatic t_ovf();
        clear_q();
        add(32'h4000_0010, 1'b1);
        exp_q = '{32'h0001_0004, 32'h4000_0010};
        run_event("R8 input ovf");
        clear_q();
        for (int i = 0; i < DEPTH + 3; i++) add(32'h4000_0000 | 32'(i));
        exp_q.push_back(32'h0001_0000 | 32'(4 * DEPTH));
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(32'h4000_0000 | 32'(i));
        run_event("R8 buffer full");
        clear_q();
        add(32'h4000_0020);
        exp_q = '{32'h0000_0004, 32'h4000_0020};
        run_event("R8 ovf cleared next event");
    endtask

    task automatic t_saturate();
        clear_q();
        for (int i = 0; i < 300; i++) add(32'h9000_0000 | 32'(i));
        exp_q = '{32'h0000_0000};
        run_event("R7 R10 many unknown");
        check("R7 bad_count saturated", 32'(bad_count), 32'((1 << CNT_W) - 1));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hits_pad();
        t_hdr_keep();
        t_hdr_strip();
        t_errors();
        t_unknown();
        t_ovf();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule